// File: doc/BRIEF.md
# Snooping Cache Coherence Controller with Transient States

This block runs the coherence state machine of one private cache attached to a snooping bus on which each transaction completes atomically in its grant cycle. A small direct-mapped tag and state array records, per set, a tag and one of four stable line states (invalid, shared, exclusive, modified). The processor side presents one block address at a time with a read/write flag and holds it until the block acknowledges; the bus side raises a request with a command and address, performs the transaction in the cycle it is granted, and at the same time watches every other cache's transactions and answers them on shared-copy, modified-copy and retry lines.

A request that has to go to the bus waits in a transient state: pending read fill, pending exclusive fill, or pending upgrade of a shared copy. A pending upgrade that sees another cache's exclusive request for the same block is turned into a full exclusive read before it is issued, so no stale upgrade ever reaches the bus. A write only acknowledges after its bus transaction, and in the acknowledge cycle of a write, an exclusive request from elsewhere for that block is told to retry so the local write always lands first.

Top module: `coh_snoop_ctl`

## Requirements
- R1: After reset every set is invalid, cpuAck and busReq are low and busCmdOut reads 3 (no command).
- R2: A processor read whose tag matches a line in shared, exclusive or modified state is looked up in the first clock edge with cpuReq high and snoopValid low; cpuAck is high for exactly the following cycle and busReq stays low.
- R3: A read that misses (invalid line or tag mismatch) raises busReq with busCmdOut 0 (shared read) in the cycle after the lookup; the line is filled in the transaction cycle as exclusive when busSharedIn is low and shared when it is high, and cpuAck is high in the next cycle.
- R4: A write hit on a modified line acknowledges like R2; a write hit on an exclusive line acknowledges like R2 and silently makes the line modified; a write to a shared line requests busCmdOut 2 (upgrade); a write miss requests busCmdOut 1 (exclusive read). After the transaction the line is modified, and cpuAck is never high while busReq is high.
- R5: While an upgrade is waiting, an observed command 1 or 2 at the same address converts the pending command to 1 from the next cycle; an observed command 0 leaves it an upgrade.
- R6: A snooped command 0 that hits a valid line raises snoopShared in that cycle; a modified line also raises snoopModified; the line ends in shared state.
- R7: A snooped command 1 or 2 that hits a valid line invalidates it; snoopModified is raised only for command 1 on a modified line; snoopShared stays low.
- R8: In the acknowledge cycle of a write, a snooped command 1 or 2 at the written address raises snoopDefer, keeps snoopShared and snoopModified low and leaves the line modified; in the acknowledge cycle of a read no retry is signalled.
- R9: The snoop path owns the tag array whenever snoopValid is high: an idle processor lookup in such a cycle is postponed by one cycle.
- R10: A bus transaction happens only in a cycle with busReq, busGrant high and snoopValid low; until then busReq, busCmdOut and busAddrOut hold.
- R11: A miss to a set holding another tag replaces that line; the old block then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuAck |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor block address (low bits select the set) |
| cpuAck | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus request while a transaction is pending |
| busCmdOut | output | 2 | 0 shared read, 1 exclusive read, 2 upgrade, 3 none |
| busAddrOut | output | ADDR_W | Address of the pending transaction |
| busGrant | input | 1 | Grant; the transaction occurs in this cycle |
| busSharedIn | input | 1 | Wired-OR shared line sampled in the own transaction cycle |
| snoopValid | input | 1 | Another cache's transaction is on the bus |
| snoopCmd | input | 2 | Command of the observed transaction, same encoding |
| snoopAddr | input | ADDR_W | Address of the observed transaction |
| snoopShared | output | 1 | This cache holds a copy (shared read only) |
| snoopModified | output | 1 | This cache holds the block modified and supplies it |
| snoopDefer | output | 1 | Retry: the local write to this block is finishing |

## Verification
The bench sweeps every set through every starting state and every snooped command, then probes the resulting state by issuing a write and watching which bus command appears; a design that dropped E to I instead of S, or left a line valid after an invalidation, shows the wrong command there. The race between two upgraders is driven directly: a controller without the transient conversion keeps issuing an upgrade for a block it no longer holds. The retry case snoops an exclusive request in the write's acknowledge cycle, where a design without deferral would report no retry and lose the block it just wrote. Tag-port contention and a grant that coincides with a snoop are also driven; a design that let the processor win would acknowledge a cycle early or complete a transaction on a busy bus.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_RD   = 2'd0,
    BUS_RDX  = 2'd1,
    BUS_UPG  = 2'd2,
    BUS_IDLE = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    PEND_IS = 2'd0,
    PEND_IM = 2'd1,
    PEND_SM = 2'd2
  } pendKind_t;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_PEND  = 2'd1,
    SRC_SNOOP = 2'd2
  } wrSrc_t;

  // strobes from the control FSM to the tag datapath
  typedef struct packed {
    logic       wrEn;
    wrSrc_t     wrSrc;
    lineState_t wrState;
    logic       capPend;
  } cohStrobe_t;

endpackage

// File: rtl/coh_tag_path.sv
module coh_tag_path
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cohStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  output lineState_t        cpuLine,
  output lineState_t        snpLine,
  output logic [ADDR_W-1:0] pendAddr,
  output logic              snpHitsPend
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [TAG_W-1:0] tagMem [SETS];
  lineState_t       stMem  [SETS];
  logic [ADDR_W-1:0] pendAddrQ;
  logic [ADDR_W-1:0] wrAddr;
  logic [IDX_W-1:0]  wrIdx;

  always_comb begin
    case (strobe.wrSrc)
      SRC_PEND:  wrAddr = pendAddrQ;
      SRC_SNOOP: wrAddr = snoopAddr;
      default:   wrAddr = cpuAddr;
    endcase
  end
  assign wrIdx = wrAddr[IDX_W-1:0];

  // one storage slot per set; each slot decodes its own write enable
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stMem[s]  <= LINE_I;
        tagMem[s] <= '0;
      end else if (strobe.wrEn && wrIdx == IDX_W'(s)) begin
        stMem[s]  <= strobe.wrState;
        tagMem[s] <= wrAddr[ADDR_W-1:IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendAddrQ <= '0;
    else if (strobe.capPend) pendAddrQ <= cpuAddr;
  end

  // two read ports: processor lookup and snoop lookup
  always_comb begin
    cpuLine = stMem[cpuAddr[IDX_W-1:0]];
    if (tagMem[cpuAddr[IDX_W-1:0]] != cpuAddr[ADDR_W-1:IDX_W]) cpuLine = LINE_I;
    snpLine = stMem[snoopAddr[IDX_W-1:0]];
    if (tagMem[snoopAddr[IDX_W-1:0]] != snoopAddr[ADDR_W-1:IDX_W]) snpLine = LINE_I;
  end

  assign pendAddr    = pendAddrQ;
  assign snpHitsPend = (snoopAddr == pendAddrQ);

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  logic       busGrant,
  input  logic       busSharedIn,
  input  logic       snoopValid,
  input  busCmd_t    snoopCmd,
  input  lineState_t cpuLine,
  input  lineState_t snpLine,
  input  logic       snpHitsPend,
  output cohStrobe_t strobe,
  output logic       cpuAck,
  output logic       busReq,
  output logic [1:0] busCmdOut,
  output logic       snoopShared,
  output logic       snoopModified,
  output logic       snoopDefer
);
  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_DONE} fsm_t;

  fsm_t      fsm, nextFsm;
  pendKind_t kind, nextKind;
  logic      doneWr, nextDoneWr;

  logic snpExcl, snpHit, deferNow;

  assign snpExcl  = snoopValid && (snoopCmd == BUS_RDX || snoopCmd == BUS_UPG);
  assign snpHit   = snoopValid && snoopCmd != BUS_IDLE && snpLine != LINE_I;
  assign deferNow = snpExcl && fsm == F_DONE && doneWr && snpHitsPend;

  assign snoopDefer    = deferNow;
  assign snoopShared   = snpHit && snoopCmd == BUS_RD;
  assign snoopModified = snpHit && !deferNow && snpLine == LINE_M && snoopCmd != BUS_UPG;

  assign cpuAck = (fsm == F_DONE);
  assign busReq = (fsm == F_WAIT);

  always_comb begin
    busCmdOut = BUS_IDLE;
    if (fsm == F_WAIT) begin
      case (kind)
        PEND_IS: busCmdOut = BUS_RD;
        PEND_IM: busCmdOut = BUS_RDX;
        default: busCmdOut = BUS_UPG;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn    = 1'b0;
    strobe.wrSrc   = SRC_CPU;
    strobe.wrState = LINE_I;
    strobe.capPend = 1'b0;
    nextFsm        = fsm;
    nextKind       = kind;
    nextDoneWr     = doneWr;

    // snoop side has priority on the tag array
    if (snpHit && !deferNow) begin
      if (snoopCmd == BUS_RD && snpLine != LINE_S) begin
        strobe.wrEn    = 1'b1;
        strobe.wrSrc   = SRC_SNOOP;
        strobe.wrState = LINE_S;
      end else if (snpExcl) begin
        strobe.wrEn    = 1'b1;
        strobe.wrSrc   = SRC_SNOOP;
        strobe.wrState = LINE_I;
      end
    end

    case (fsm)
      F_IDLE: begin
        if (cpuReq && !snoopValid) begin
          strobe.capPend = 1'b1;
          if (!cpuWrite) begin
            if (cpuLine != LINE_I) begin
              nextFsm    = F_DONE;
              nextDoneWr = 1'b0;
            end else begin
              nextFsm  = F_WAIT;
              nextKind = PEND_IS;
            end
          end else begin
            case (cpuLine)
              LINE_M: begin
                nextFsm    = F_DONE;
                nextDoneWr = 1'b1;
              end
              LINE_E: begin
                strobe.wrEn    = 1'b1;
                strobe.wrSrc   = SRC_CPU;
                strobe.wrState = LINE_M;
                nextFsm        = F_DONE;
                nextDoneWr     = 1'b1;
              end
              LINE_S: begin
                nextFsm  = F_WAIT;
                nextKind = PEND_SM;
              end
              default: begin
                nextFsm  = F_WAIT;
                nextKind = PEND_IM;
              end
            endcase
          end
        end
      end
      F_WAIT: begin
        if (snoopValid) begin
          // a competing writer took the block: upgrade is no longer enough
          if (kind == PEND_SM && snpExcl && snpHitsPend) nextKind = PEND_IM;
        end else if (busGrant) begin
          strobe.wrEn    = 1'b1;
          strobe.wrSrc   = SRC_PEND;
          strobe.wrState = (kind == PEND_IS) ? (busSharedIn ? LINE_S : LINE_E) : LINE_M;
          nextFsm        = F_DONE;
          nextDoneWr     = (kind != PEND_IS);
        end
      end
      default: nextFsm = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm    <= F_IDLE;
      kind   <= PEND_IS;
      doneWr <= 1'b0;
    end else begin
      fsm    <= nextFsm;
      kind   <= nextKind;
      doneWr <= nextDoneWr;
    end
  end

endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuAck,
  output logic              busReq,
  output logic [1:0]        busCmdOut,
  output logic [ADDR_W-1:0] busAddrOut,
  input  logic              busGrant,
  input  logic              busSharedIn,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopShared,
  output logic              snoopModified,
  output logic              snoopDefer
);
  localparam int IDX_W = $clog2(SETS);

  cohStrobe_t strobe;
  lineState_t cpuLine, snpLine;
  logic       snpHitsPend;
  busCmd_t    snoopCmdE;

  assign snoopCmdE = busCmd_t'(snoopCmd);

  coh_tag_path #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuAddr    (cpuAddr),
    .snoopAddr  (snoopAddr),
    .cpuLine    (cpuLine),
    .snpLine    (snpLine),
    .pendAddr   (busAddrOut),
    .snpHitsPend(snpHitsPend)
  );

  coh_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuWrite     (cpuWrite),
    .busGrant     (busGrant),
    .busSharedIn  (busSharedIn),
    .snoopValid   (snoopValid),
    .snoopCmd     (snoopCmdE),
    .cpuLine      (cpuLine),
    .snpLine      (snpLine),
    .snpHitsPend  (snpHitsPend),
    .strobe       (strobe),
    .cpuAck       (cpuAck),
    .busReq       (busReq),
    .busCmdOut    (busCmdOut),
    .snoopShared  (snoopShared),
    .snoopModified(snoopModified),
    .snoopDefer   (snoopDefer)
  );

endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuAck,
  input logic              busReq,
  input logic [1:0]        busCmdOut,
  input logic [ADDR_W-1:0] busAddrOut,
  input logic              busGrant,
  input logic              snoopValid,
  input logic [1:0]        snoopCmd,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic              snoopShared,
  input logic              snoopModified,
  input logic              snoopDefer
);

  p_ack_after_txn_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && !snoopValid |=> cpuAck && !busReq);

  p_serial_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !cpuAck);

  p_upg_convert_r5: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmdOut == 2'd2 && snoopValid && snoopCmd != 2'd0 && snoopCmd != 2'd3
      && snoopAddr == busAddrOut |=> busReq && busCmdOut == 2'd1);

  p_mod_shared_r6: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid && snoopCmd == 2'd0 && snoopModified |-> snoopShared);

  p_excl_no_shared_r7: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid && snoopCmd != 2'd0 |-> !snoopShared);

  p_defer_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    snoopDefer |-> cpuAck && !snoopShared && !snoopModified);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && snoopValid && !busReq && !cpuAck |=> !cpuAck && !busReq);

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !(busGrant && !snoopValid) |=> busReq && $stable(busAddrOut) && busCmdOut != 2'd3);

endmodule

bind coh_snoop_ctl coh_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuReq       (cpuReq),
  .cpuAck       (cpuAck),
  .busReq       (busReq),
  .busCmdOut    (busCmdOut),
  .busAddrOut   (busAddrOut),
  .busGrant     (busGrant),
  .snoopValid   (snoopValid),
  .snoopCmd     (snoopCmd),
  .snoopAddr    (snoopAddr),
  .snoopShared  (snoopShared),
  .snoopModified(snoopModified),
  .snoopDefer   (snoopDefer)
);

// File: tb/sim_coh_snoop_ctl.sv
`timescale 1ns/100ps
module sim_coh_snoop_ctl;
  localparam int AW = 8;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_NONE = 2'd3;
  localparam int L_I = 0, L_S = 1, L_E = 2, L_M = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic cpuAck, busReq;
  logic [1:0] busCmdOut;
  logic [AW-1:0] busAddrOut;
  logic busGrant = 1'b0, busSharedIn = 1'b0;
  logic snoopValid = 1'b0;
  logic [1:0] snoopCmd = 2'd0;
  logic [AW-1:0] snoopAddr = '0;
  logic snoopShared, snoopModified, snoopDefer;

  int checks = 0;
  int failures = 0;
  int tagSeed = 1;

  always #2.5 clk = ~clk;

  coh_snoop_ctl #(.ADDR_W(AW), .SETS(4)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuAck(cpuAck), .busReq(busReq), .busCmdOut(busCmdOut), .busAddrOut(busAddrOut),
    .busGrant(busGrant), .busSharedIn(busSharedIn), .snoopValid(snoopValid),
    .snoopCmd(snoopCmd), .snoopAddr(snoopAddr), .snoopShared(snoopShared),
    .snoopModified(snoopModified), .snoopDefer(snoopDefer)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // processor op; expCmd == C_NONE means a hit that acks without the bus
  task automatic cpuOp(input bit w, input logic [AW-1:0] a, input logic [1:0] expCmd,
                       input bit sh, input string req);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = w; cpuAddr = a;
    @(negedge clk);
    if (expCmd == C_NONE) begin
      chk(cpuAck == 1'b1 && busReq == 1'b0, req, "hit ack/req", {cpuAck, busReq}, 2'b10);
    end else begin
      chk(busReq && busCmdOut == expCmd && busAddrOut == a && !cpuAck, req, "bus cmd",
          busCmdOut, expCmd);
      busGrant = 1'b1; busSharedIn = sh;
      @(negedge clk);
      busGrant = 1'b0; busSharedIn = 1'b0;
      chk(cpuAck == 1'b1 && busReq == 1'b0, req, "ack after txn", {cpuAck, busReq}, 2'b10);
    end
    cpuReq = 1'b0;
  endtask

  task automatic snp(input logic [1:0] cmd, input logic [AW-1:0] a, input bit eSh,
                     input bit eMod, input bit eDef, input string req);
    @(negedge clk);
    snoopValid = 1'b1; snoopCmd = cmd; snoopAddr = a;
    #1;
    chk({snoopShared, snoopModified, snoopDefer} == {eSh, eMod, eDef}, req, "snoop resp",
        {snoopShared, snoopModified, snoopDefer}, {eSh, eMod, eDef});
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  task automatic setLine(input int st, input logic [AW-1:0] a, input string req);
    case (st)
      L_S: cpuOp(1'b0, a, C_RD, 1'b1, req);
      L_E: cpuOp(1'b0, a, C_RD, 1'b0, req);
      default: cpuOp(1'b1, a, C_RDX, 1'b0, req);
    endcase
  endtask

  function automatic logic [AW-1:0] freshAddr(input int idx);
    tagSeed++;
    return {tagSeed[5:0], idx[1:0]};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] a, b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cpuAck && !busReq && busCmdOut == C_NONE, "R1", "reset outputs",
        {cpuAck, busReq, busCmdOut}, {2'b00, C_NONE});
    a = freshAddr(0);
    cpuOp(1'b0, a, C_RD, 1'b0, "R1");   // cold miss after reset

    // sweep: every set x every start state x every snooped command
    for (int idx = 0; idx < 4; idx++) begin
      for (int st = L_S; st <= L_M; st++) begin
        for (int c = 0; c < 3; c++) begin
          bit eSh, eMod;
          int nst;
          a = freshAddr(idx);
          setLine(st, a, st == L_M ? "R4" : "R3");
          cpuOp(1'b0, a, C_NONE, 1'b0, "R2");
          eSh  = (c == 0);
          eMod = (st == L_M) && (c != 2);
          nst  = (c == 0) ? L_S : L_I;
          snp(c[1:0], a, eSh, eMod, 1'b0, c == 0 ? "R6" : "R7");
          if (nst == L_S) cpuOp(1'b1, a, C_UPG, 1'b0, "R6");
          else cpuOp(1'b1, a, C_RDX, 1'b0, "R7");
        end
      end
    end

    // R4 write hits: E silently becomes M, M stays M
    a = freshAddr(1);
    setLine(L_E, a, "R4");
    cpuOp(1'b1, a, C_NONE, 1'b0, "R4");
    cpuOp(1'b1, a, C_NONE, 1'b0, "R4");
    snp(C_RD, a, 1'b1, 1'b1, 1'b0, "R4");

    // R11 replacement within a set
    a = freshAddr(2);
    b = freshAddr(2);
    setLine(L_M, a, "R11");
    cpuOp(1'b0, b, C_RD, 1'b0, "R11");
    cpuOp(1'b0, a, C_RD, 1'b1, "R11");
    cpuOp(1'b0, b, C_RD, 1'b1, "R11");

    // R5 pending upgrade converted by a competing upgrade
    a = freshAddr(3);
    setLine(L_S, a, "R5");
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b1; cpuAddr = a;
    @(negedge clk);
    chk(busReq && busCmdOut == C_UPG, "R5", "pending upgrade", busCmdOut, C_UPG);
    snoopValid = 1'b1; snoopCmd = C_RD; snoopAddr = a;
    #1;
    chk(snoopShared && !snoopModified, "R5", "read snoop while pending", snoopShared, 1);
    @(negedge clk);
    chk(busReq && busCmdOut == C_UPG, "R5", "still upgrade after read", busCmdOut, C_UPG);
    snoopCmd = C_UPG;
    @(negedge clk);
    snoopValid = 1'b0;
    chk(busReq && busCmdOut == C_RDX && !cpuAck, "R5", "converted cmd", busCmdOut, C_RDX);
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    chk(cpuAck && !busReq, "R5", "ack after converted txn", cpuAck, 1);
    cpuReq = 1'b0;
    snp(C_RD, a, 1'b1, 1'b1, 1'b0, "R5");

    // R8 deferral in the write ack cycle
    a = freshAddr(0);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b1; cpuAddr = a;
    @(negedge clk);
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0; cpuReq = 1'b0;
    chk(cpuAck, "R8", "write ack", cpuAck, 1);
    snoopValid = 1'b1; snoopCmd = C_RDX; snoopAddr = a;
    #1;
    chk(snoopDefer && !snoopShared && !snoopModified, "R8", "defer",
        {snoopDefer, snoopShared, snoopModified}, 3'b100);
    @(negedge clk);
    snoopValid = 1'b0;
    snp(C_RD, a, 1'b1, 1'b1, 1'b0, "R8");
    // no deferral in a read ack cycle
    a = freshAddr(1);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = a;
    @(negedge clk);
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0; cpuReq = 1'b0;
    snoopValid = 1'b1; snoopCmd = C_RDX; snoopAddr = a;
    #1;
    chk(!snoopDefer && !snoopModified, "R8", "no defer on read", snoopDefer, 0);
    @(negedge clk);
    snoopValid = 1'b0;
    cpuOp(1'b0, a, C_RD, 1'b0, "R8");

    // R9 snoop wins the tag port
    a = freshAddr(2);
    setLine(L_E, a, "R9");
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = a;
    snoopValid = 1'b1; snoopCmd = C_RD; snoopAddr = freshAddr(3);
    @(negedge clk);
    snoopValid = 1'b0;
    chk(!cpuAck && !busReq, "R9", "stalled lookup", cpuAck, 0);
    @(negedge clk);
    chk(cpuAck && !busReq, "R9", "delayed hit ack", cpuAck, 1);
    cpuReq = 1'b0;

    // R10 grant during a snoop does not complete the transaction
    a = freshAddr(0);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b1; cpuAddr = a;
    @(negedge clk);
    chk(busReq && busCmdOut == C_RDX && busAddrOut == a, "R10", "request", busCmdOut, C_RDX);
    busGrant = 1'b1;
    snoopValid = 1'b1; snoopCmd = C_RD; snoopAddr = freshAddr(1);
    @(negedge clk);
    snoopValid = 1'b0;
    chk(busReq && !cpuAck && busAddrOut == a && busCmdOut == C_RDX, "R10", "held request",
        {busReq, cpuAck}, 2'b10);
    @(negedge clk);
    busGrant = 1'b0;
    chk(cpuAck && !busReq, "R10", "ack after clean grant", cpuAck, 1);
    cpuReq = 1'b0;
    snp(C_RD, a, 1'b1, 1'b1, 1'b0, "R10");

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule